// File: doc/BRIEF.md
# Host Adapter Control Register Window

This block is a 64-byte window of control registers that a 16-bit host processor writes with byte or word stores. Every word slot applies its own mask of writable bits, so bits outside the mask keep their value and unmapped slots stay at zero. Some writes also raise one-cycle event strobes towards the rest of the adapter: a slave-processor reset, an interrupt-control update, a bank switch, a communication-slot update, and a push of a data word into a FIFO or into a pulse-width channel.

The host is big-endian. A byte store to an even address targets bits 15:8 of the word, and a byte store to an odd address targets bits 7:0. A word store ignores address bit 0. Byte data always arrives on `wr_data[7:0]`. The four push registers are written in two halves. Each has its own two-state lane machine. The states are LANE_EMPTY and LANE_HELD, and the transitions are:
- latch: LANE_EMPTY to LANE_HELD on an even-byte store.
- relatch: LANE_HELD to LANE_HELD on another even-byte store, which replaces the held byte.
- merge: LANE_HELD to LANE_EMPTY on an odd-byte store, which pushes {held, new}.
- direct: any state to LANE_EMPTY on a word store, which pushes the word.
- lone: LANE_EMPTY to LANE_EMPTY on an odd-byte store, which pushes {0x00, new}.

The eight communication slots record a dirty bit for each slot. A consumer clears a dirty bit by acknowledging that slot. Reads use a separate word index and return the stored word without a clock edge.

Top module: `adreg_window`

## Requirements
- R1: After reset, every word reads 0. All strobes and push outputs are low and `comm_dirty` is 0.
- R2: Each word keeps only its writable bits. A store changes only the bits that are both in the word's mask and in the addressed byte lane. The masks by byte offset are: 0x00 0x8003, 0x02 0x0003, 0x04 0x0003, 0x08 0x00FF, 0x0A 0xFFFE, 0x0C 0x00FF, 0x0E 0xFFFF, 0x10 0xFFFC, 0x1A 0x0101, 0x30 0x000F.
- R3: Word 0x00 holds FM in bit 15, nRES in bit 1 and ADEN in bit 0. When a store moves nRES from 0 to 1, `slave_rst` is high for exactly the one cycle after the write edge.
- R4: When a store changes bits 1:0 of word 0x02, `irq_upd` pulses for one cycle after the write edge. A store that leaves those bits unchanged gives no pulse.
- R5: When a store changes bits 1:0 of word 0x04 (bank), `bank_sw` pulses for one cycle after the write edge. A store that leaves those bits unchanged gives no pulse.
- R6: Any offset with no mask in R2 ignores stores and reads as 0. This includes 0x02 even, 0x08 even, 0x14–0x19, 0x3A–0x3F and the push registers.
- R7: A word store to a push register gives `push_vld` for one cycle after the write edge, with the word on `push_data`. The values of `push_sel` are: 0 for FIFO 0x12, 1 for 0x34, 2 for 0x36, 3 for 0x38.
- R8: An even-byte store to a push register only latches the byte. The next odd-byte store to the same register pushes {latched, new} and clears the latch. An odd-byte store with nothing latched pushes {0x00, new}. Each register has its own latch.
- R9: A store to a communication slot (0x20–0x2F) that leaves the slot value unchanged is ignored. It gives no `comm_upd` and leaves `comm_dirty` as it was.
- R10: Any other store to a communication slot updates the slot and sets `comm_dirty` bit (offset & 0xF)/2. It also pulses `comm_upd` for one cycle, with that index on `comm_upd_idx`.
- R11: A high `comm_ack` bit clears the matching dirty bit at the next edge. If a store sets the same bit in that cycle, the set takes priority.
- R12: `rd_data` returns the word at `rd_widx` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = word store, 0 = byte store |
| wr_addr | input | 6 | Byte address of the store |
| wr_data | input | 16 | Store data (byte stores use bits 7:0) |
| rd_widx | input | 5 | Word index to read |
| rd_data | output | 16 | Stored word at `rd_widx` |
| comm_ack | input | 8 | Per-slot dirty acknowledge |
| slave_rst | output | 1 | Slave reset pulse |
| irq_upd | output | 1 | Interrupt control changed |
| bank_sw | output | 1 | Bank select changed |
| comm_upd | output | 1 | Communication slot updated |
| comm_upd_idx | output | 3 | Index of the updated slot |
| comm_dirty | output | 8 | Dirty flag for each slot |
| push_vld | output | 1 | Push strobe |
| push_sel | output | 2 | Push target |
| push_data | output | 16 | Pushed word |

## Verification
The bench builds the block with its default parameters: a 6-bit address, a 16-bit word and eight communication slots. With these values all 32 word slots can be read, the highest slot index 7 can be reached, and all four push lanes can be driven. The bench interleaves half-writes across lanes to show that each lane keeps its own latch. It also collides an acknowledge with a store to the same slot to check which one takes priority.

// File: rtl/adreg_pkg.sv
package adreg_pkg;

    typedef enum logic {
        LANE_EMPTY,
        LANE_HELD
    } lane_state_e;

    localparam int LANE_NUM = 4;

    // writable bits per word index (byte offset / 2)
    function automatic logic [15:0] field_mask(input logic [4:0] widx);
        logic [15:0] m;
        unique case (widx)
            5'd0:    m = 16'h8003;  // adapter control
            5'd1:    m = 16'h0003;  // interrupt control
            5'd2:    m = 16'h0003;  // bank
            5'd4:    m = 16'h00FF;  // transfer source high
            5'd5:    m = 16'hFFFE;  // transfer source low
            5'd6:    m = 16'h00FF;  // transfer destination high
            5'd7:    m = 16'hFFFF;  // transfer destination low
            5'd8:    m = 16'hFFFC;  // transfer length
            5'd13:   m = 16'h0101;  // video mode pair
            5'd24:   m = 16'h000F;  // pulse-width control
            default: m = 16'h0000;
        endcase
        return m;
    endfunction

    // word index of each push lane, lane order is the push_sel code
    function automatic logic [4:0] lane_word(input int lane);
        logic [4:0] w;
        unique case (lane)
            0:       w = 5'd9;
            1:       w = 5'd26;
            2:       w = 5'd27;
            default: w = 5'd28;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/adreg_push_lane.sv
module adreg_push_lane
    import adreg_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              wr_word,
    input  logic              wr_odd,
    input  logic [WORD_W-1:0] wr_data,
    output logic              push_o,
    output logic [WORD_W-1:0] data_o
);
    localparam int BYTE_W = WORD_W / 2;

    lane_state_e       state_q, state_d;
    logic [BYTE_W-1:0] hold_q;
    logic              fire;

    assign fire = hit && (wr_word || wr_odd);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_EMPTY: if (hit && !wr_word && !wr_odd) state_d = LANE_HELD;
            LANE_HELD:  if (fire) state_d = LANE_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LANE_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            push_o <= 1'b0;
            data_o <= '0;
        end else begin
            push_o <= fire;
            if (hit) begin
                if (fire) hold_q <= '0;
                else      hold_q <= wr_data[BYTE_W-1:0];
            end
            if (fire) begin
                if (wr_word) data_o <= wr_data;
                else         data_o <= {hold_q, wr_data[BYTE_W-1:0]};
            end
        end
    end

    p_push_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (state_q == LANE_EMPTY && hold_q == '0));
    p_empty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_EMPTY) |-> (hold_q == '0));

endmodule

// File: rtl/adreg_ctrl_bank.sv
module adreg_ctrl_bank
    import adreg_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_widx,
    input  logic [WORD_W-1:0] lane_mask,
    input  logic [WORD_W-1:0] merged,
    input  logic [WIDX_W-1:0] rd_widx,
    output logic [WORD_W-1:0] rd_word,
    output logic              slave_rst_o,
    output logic              irq_upd_o,
    output logic              bank_sw_o
);
    localparam int NWORDS = 2 ** WIDX_W;
    localparam logic [WORD_W-1:0] M_CTL  = field_mask(5'd0);
    localparam logic [WORD_W-1:0] M_IRQ  = field_mask(5'd1);
    localparam logic [WORD_W-1:0] M_BANK = field_mask(5'd2);

    logic [WORD_W-1:0] q [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [WORD_W-1:0] M = field_mask(5'(w));
        if (M != '0) begin : g_live
            logic [WORD_W-1:0] r;
            always_ff @(posedge clk) begin
                if (!rst_n) r <= '0;
                else if (wr_en && wr_widx == WIDX_W'(w))
                    r <= (r & ~(M & lane_mask)) | (merged & M & lane_mask);
            end
            assign q[w] = r;
        end else begin : g_dead
            assign q[w] = '0;
        end
    end

    logic [WORD_W-1:0] m_ctl, m_irq, m_bank;
    logic              nres_next;
    logic [1:0]        irq_next, bank_next;

    always_comb begin
        m_ctl     = M_CTL & lane_mask;
        m_irq     = M_IRQ & lane_mask;
        m_bank    = M_BANK & lane_mask;
        nres_next = (q[0][1] & ~m_ctl[1]) | (merged[1] & m_ctl[1]);
        irq_next  = (q[1][1:0] & ~m_irq[1:0]) | (merged[1:0] & m_irq[1:0]);
        bank_next = (q[2][1:0] & ~m_bank[1:0]) | (merged[1:0] & m_bank[1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_rst_o <= 1'b0;
            irq_upd_o   <= 1'b0;
            bank_sw_o   <= 1'b0;
        end else begin
            slave_rst_o <= wr_en && wr_widx == WIDX_W'(0) && !q[0][1] && nres_next;
            irq_upd_o   <= wr_en && wr_widx == WIDX_W'(1) && irq_next != q[1][1:0];
            bank_sw_o   <= wr_en && wr_widx == WIDX_W'(2) && bank_next != q[2][1:0];
        end
    end

    assign rd_word = q[rd_widx];

    p_rst_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slave_rst_o |-> (q[0][1] && !$past(q[0][1])));
    p_irq_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_upd_o |-> (q[1][1:0] != $past(q[1][1:0])));
    p_bank_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sw_o |-> (q[2][1:0] != $past(q[2][1:0])));
    p_bank_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q[2][1:0] != $past(q[2][1:0])) |-> bank_sw_o);

endmodule

// File: rtl/adreg_comm_bank.sv
module adreg_comm_bank #(
    parameter int WORD_W   = 16,
    parameter int COMM_NUM = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        hit,
    input  logic [$clog2(COMM_NUM)-1:0] wr_idx,
    input  logic [WORD_W-1:0]           lane_mask,
    input  logic [WORD_W-1:0]           merged,
    input  logic [COMM_NUM-1:0]         ack,
    input  logic [$clog2(COMM_NUM)-1:0] rd_idx,
    output logic [WORD_W-1:0]           rd_word,
    output logic [COMM_NUM-1:0]         dirty_o,
    output logic                        upd_o,
    output logic [$clog2(COMM_NUM)-1:0] upd_idx_o
);
    localparam int IDX_W = $clog2(COMM_NUM);

    logic [COMM_NUM-1:0][WORD_W-1:0] q;
    logic [WORD_W-1:0]               next_word;
    logic                            change;
    logic [COMM_NUM-1:0]             set_vec;

    always_comb begin
        next_word = (q[wr_idx] & ~lane_mask) | (merged & lane_mask);
        change    = wr_en && hit && (next_word != q[wr_idx]);
        set_vec   = '0;
        if (change) set_vec[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            dirty_o   <= '0;
            upd_o     <= 1'b0;
            upd_idx_o <= '0;
        end else begin
            if (change) begin
                q[wr_idx] <= next_word;
                upd_idx_o <= wr_idx;
            end
            upd_o   <= change;
            dirty_o <= (dirty_o & ~ack) | set_vec;
        end
    end

    assign rd_word = q[rd_idx];

    p_upd_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> dirty_o[upd_idx_o]);
    p_upd_changed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (q != $past(q)));
    p_silent_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> upd_o);
    p_dirty_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dirty_o & ~$past(dirty_o)) > 0) |-> upd_o);

    initial begin
        assert (IDX_W >= 1) else $error("comm bank needs two or more slots");
    end

endmodule

// File: rtl/adreg_window.sv
module adreg_window
    import adreg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WORD_W   = 16,
    parameter int COMM_NUM = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_word,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [ADDR_W-2:0]           rd_widx,
    output logic [WORD_W-1:0]           rd_data,
    input  logic [COMM_NUM-1:0]         comm_ack,
    output logic                        slave_rst,
    output logic                        irq_upd,
    output logic                        bank_sw,
    output logic                        comm_upd,
    output logic [$clog2(COMM_NUM)-1:0] comm_upd_idx,
    output logic [COMM_NUM-1:0]         comm_dirty,
    output logic                        push_vld,
    output logic [1:0]                  push_sel,
    output logic [WORD_W-1:0]           push_data
);
    localparam int WIDX_W     = ADDR_W - 1;
    localparam int BYTE_W     = WORD_W / 2;
    localparam int CIDX_W     = $clog2(COMM_NUM);
    localparam int COMM_WBASE = 16;
    localparam logic [WIDX_W-1:0] COMM_TAG = WIDX_W'(COMM_WBASE >> CIDX_W);

    logic [WIDX_W-1:0] wr_widx;
    logic              wr_odd;
    logic [WORD_W-1:0] lane_mask, merged;

    always_comb begin
        wr_widx = wr_addr[ADDR_W-1:1];
        wr_odd  = wr_addr[0];
        if (wr_word) begin
            lane_mask = '1;
            merged    = wr_data;
        end else if (wr_odd) begin
            lane_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
            merged    = {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
        end else begin
            lane_mask = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
            merged    = {wr_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
    end

    logic [WORD_W-1:0] ctrl_rd, comm_rd;

    adreg_ctrl_bank #(.WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_widx     (wr_widx),
        .lane_mask   (lane_mask),
        .merged      (merged),
        .rd_widx     (rd_widx),
        .rd_word     (ctrl_rd),
        .slave_rst_o (slave_rst),
        .irq_upd_o   (irq_upd),
        .bank_sw_o   (bank_sw)
    );

    logic comm_wr_hit, comm_rd_hit;
    assign comm_wr_hit = (wr_widx >> CIDX_W) == COMM_TAG;
    assign comm_rd_hit = (rd_widx >> CIDX_W) == COMM_TAG;

    adreg_comm_bank #(.WORD_W(WORD_W), .COMM_NUM(COMM_NUM)) u_comm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .hit       (comm_wr_hit),
        .wr_idx    (wr_widx[CIDX_W-1:0]),
        .lane_mask (lane_mask),
        .merged    (merged),
        .ack       (comm_ack),
        .rd_idx    (rd_widx[CIDX_W-1:0]),
        .rd_word   (comm_rd),
        .dirty_o   (comm_dirty),
        .upd_o     (comm_upd),
        .upd_idx_o (comm_upd_idx)
    );

    assign rd_data = comm_rd_hit ? comm_rd : ctrl_rd;

    logic [LANE_NUM-1:0] lane_push;
    logic [WORD_W-1:0]   lane_data [LANE_NUM];

    for (genvar l = 0; l < LANE_NUM; l++) begin : g_lane
        logic lane_hit;
        assign lane_hit = wr_en && (wr_widx == WIDX_W'(lane_word(l)));
        adreg_push_lane #(.WORD_W(WORD_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (lane_hit),
            .wr_word (wr_word),
            .wr_odd  (wr_odd),
            .wr_data (wr_data),
            .push_o  (lane_push[l]),
            .data_o  (lane_data[l])
        );
    end

    always_comb begin
        push_vld  = 1'b0;
        push_sel  = '0;
        push_data = '0;
        for (int l = 0; l < LANE_NUM; l++) begin
            if (lane_push[l]) begin
                push_vld  = 1'b1;
                push_sel  = 2'(l);
                push_data = lane_data[l];
            end
        end
    end

    p_one_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_push));
    p_push_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |-> $past(wr_en));

endmodule

// File: tb/adreg_window_bench.sv
module adreg_window_bench;

    localparam real CYC_NS = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_widx = '0;
    logic [15:0] rd_data;
    logic [7:0]  comm_ack = '0;
    logic        slave_rst, irq_upd, bank_sw, comm_upd, push_vld;
    logic [2:0]  comm_upd_idx;
    logic [7:0]  comm_dirty;
    logic [1:0]  push_sel;
    logic [15:0] push_data;

    always #(CYC_NS / 2.0) clk = ~clk;

    adreg_window u_adreg_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_word      (wr_word),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_widx      (rd_widx),
        .rd_data      (rd_data),
        .comm_ack     (comm_ack),
        .slave_rst    (slave_rst),
        .irq_upd      (irq_upd),
        .bank_sw      (bank_sw),
        .comm_upd     (comm_upd),
        .comm_upd_idx (comm_upd_idx),
        .comm_dirty   (comm_dirty),
        .push_vld     (push_vld),
        .push_sel     (push_sel),
        .push_data    (push_data)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    typedef struct packed {
        logic        w;
        logic [5:0]  a;
        logic [15:0] d;
        logic [5:0]  ra;
        logic [15:0] e;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h00, 16'hFFFF, 6'h00, 16'h8003},
        '{1'b0, 6'h01, 16'h0000, 6'h00, 16'h8000},
        '{1'b0, 6'h00, 16'h0000, 6'h00, 16'h0000},
        '{1'b1, 6'h08, 16'hABCD, 6'h09, 16'h00CD},
        '{1'b0, 6'h08, 16'h0055, 6'h08, 16'h00CD},
        '{1'b1, 6'h0A, 16'h1235, 6'h0A, 16'h1234},
        '{1'b0, 6'h0B, 16'h00FF, 6'h0A, 16'h12FE},
        '{1'b1, 6'h10, 16'hFFFF, 6'h10, 16'hFFFC},
        '{1'b0, 6'h11, 16'h0007, 6'h10, 16'hFF04},
        '{1'b0, 6'h1A, 16'h00FF, 6'h1A, 16'h0100},
        '{1'b0, 6'h1B, 16'h0003, 6'h1A, 16'h0101},
        '{1'b1, 6'h30, 16'hFFFF, 6'h30, 16'h000F},
        '{1'b0, 6'h30, 16'h00AA, 6'h30, 16'h000F},
        '{1'b0, 6'h31, 16'h0035, 6'h30, 16'h0005},
        '{1'b1, 6'h14, 16'hFFFF, 6'h14, 16'h0000},
        '{1'b1, 6'h0C, 16'h1234, 6'h0C, 16'h0034},
        '{1'b1, 6'h0E, 16'hBEEF, 6'h0E, 16'hBEEF},
        '{1'b0, 6'h3B, 16'h00FF, 6'h3A, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic w, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_word = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        rd_widx = a[5:1];
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic idle;
        @(posedge clk);
        #1;
    endtask

    task automatic ack(input logic [7:0] m);
        @(negedge clk);
        comm_ack = m;
        @(posedge clk);
        #1;
        comm_ack = '0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int i = 0; i < 32; i++) rd_chk("R1 reset read", 6'(i * 2), 16'h0000);
        chk("R1 strobes", {28'h0, slave_rst, irq_upd, bank_sw, push_vld}, 32'h0);
        chk("R1 dirty", 32'(comm_dirty), 32'h0);
        chk("R1 comm_upd", 32'(comm_upd), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 masks table (entries at 0x14 and 0x3A also cover R6)
        for (int i = 0; i < NV; i++) begin
            do_wr(VECS[i].w, VECS[i].a, VECS[i].d);
            rd_chk("R2 mask vector", VECS[i].ra, VECS[i].e);
        end

        // R3 nRES rising edge
        do_wr(1'b1, 6'h00, 16'h0002);
        chk("R3 pulse on rise", 32'(slave_rst), 32'h1);
        idle();
        chk("R3 pulse one cycle", 32'(slave_rst), 32'h0);
        do_wr(1'b1, 6'h00, 16'h0003);
        chk("R3 no pulse when held", 32'(slave_rst), 32'h0);
        do_wr(1'b0, 6'h01, 16'h0000);
        do_wr(1'b0, 6'h01, 16'h0002);
        chk("R3 pulse on byte rise", 32'(slave_rst), 32'h1);

        // R4 interrupt control
        do_wr(1'b0, 6'h03, 16'h0001);
        chk("R4 strobe on change", 32'(irq_upd), 32'h1);
        rd_chk("R4 stored", 6'h02, 16'h0001);
        do_wr(1'b0, 6'h03, 16'h00FD);
        chk("R4 no strobe same bits", 32'(irq_upd), 32'h0);
        do_wr(1'b0, 6'h02, 16'h00FF);
        chk("R6 even irq byte no strobe", 32'(irq_upd), 32'h0);
        rd_chk("R6 even irq byte ignored", 6'h02, 16'h0001);
        do_wr(1'b1, 6'h02, 16'h0006);
        chk("R4 word strobe", 32'(irq_upd), 32'h1);
        rd_chk("R4 word stored", 6'h02, 16'h0002);

        // R5 bank
        do_wr(1'b0, 6'h05, 16'h0003);
        chk("R5 switch on change", 32'(bank_sw), 32'h1);
        rd_chk("R5 stored", 6'h04, 16'h0003);
        do_wr(1'b0, 6'h05, 16'h0003);
        chk("R5 no switch same", 32'(bank_sw), 32'h0);
        do_wr(1'b1, 6'h04, 16'hFF01);
        chk("R5 word switch", 32'(bank_sw), 32'h1);
        rd_chk("R5 word stored", 6'h04, 16'h0001);

        // R6 other dead offsets
        do_wr(1'b1, 6'h18, 16'hFFFF);
        rd_chk("R6 offset 0x18", 6'h18, 16'h0000);
        do_wr(1'b1, 6'h3E, 16'hFFFF);
        rd_chk("R6 offset 0x3E", 6'h3E, 16'h0000);

        // R7 direct word pushes
        do_wr(1'b1, 6'h12, 16'hCAFE);
        chk("R7 push valid", 32'(push_vld), 32'h1);
        chk("R7 fifo sel", 32'(push_sel), 32'h0);
        chk("R7 fifo data", 32'(push_data), 32'hCAFE);
        idle();
        chk("R7 push one cycle", 32'(push_vld), 32'h0);
        do_wr(1'b1, 6'h38, 16'h1234);
        chk("R7 lane3 sel", 32'(push_sel), 32'h3);
        chk("R7 lane3 data", 32'(push_data), 32'h1234);
        rd_chk("R6 push reg reads zero", 6'h38, 16'h0000);

        // R8 split pushes
        do_wr(1'b0, 6'h34, 16'h00AB);
        chk("R8 even byte no push", 32'(push_vld), 32'h0);
        rd_chk("R8 latch not readable", 6'h34, 16'h0000);
        do_wr(1'b0, 6'h35, 16'h00CD);
        chk("R8 merge push", 32'(push_vld), 32'h1);
        chk("R8 merge sel", 32'(push_sel), 32'h1);
        chk("R8 merge data", 32'(push_data), 32'hABCD);
        do_wr(1'b0, 6'h35, 16'h0011);
        chk("R8 latch cleared", 32'(push_data), 32'h0011);
        do_wr(1'b0, 6'h36, 16'h0099);
        do_wr(1'b0, 6'h13, 16'h0001);
        chk("R8 lanes independent sel", 32'(push_sel), 32'h0);
        chk("R8 lanes independent data", 32'(push_data), 32'h0001);
        do_wr(1'b0, 6'h37, 16'h0002);
        chk("R8 lane2 kept latch", 32'(push_data), 32'h9902);
        chk("R8 lane2 sel", 32'(push_sel), 32'h2);
        do_wr(1'b0, 6'h12, 16'h0077);
        do_wr(1'b0, 6'h12, 16'h0078);
        do_wr(1'b0, 6'h13, 16'h0088);
        chk("R8 relatch", 32'(push_data), 32'h7888);

        // R10 comm updates
        do_wr(1'b1, 6'h24, 16'h5555);
        chk("R10 upd", 32'(comm_upd), 32'h1);
        chk("R10 idx", 32'(comm_upd_idx), 32'h2);
        chk("R10 dirty", 32'(comm_dirty), 32'h04);
        rd_chk("R12 comm read", 6'h24, 16'h5555);
        do_wr(1'b0, 6'h2F, 16'h0066);
        chk("R10 top idx", 32'(comm_upd_idx), 32'h7);
        chk("R10 dirty top", 32'(comm_dirty), 32'h84);
        rd_chk("R10 byte stored", 6'h2E, 16'h0066);

        // R11 ack, then R9 equal writes
        ack(8'h04);
        chk("R11 ack clears", 32'(comm_dirty), 32'h80);
        do_wr(1'b1, 6'h24, 16'h5555);
        chk("R9 equal word no upd", 32'(comm_upd), 32'h0);
        chk("R9 dirty unchanged", 32'(comm_dirty), 32'h80);
        do_wr(1'b0, 6'h24, 16'h0055);
        chk("R9 equal byte no upd", 32'(comm_upd), 32'h0);
        chk("R9 dirty unchanged byte", 32'(comm_dirty), 32'h80);
        comm_ack = 8'h80;
        do_wr(1'b1, 6'h2E, 16'h1111);
        comm_ack = '0;
        chk("R11 set wins over ack", 32'(comm_dirty), 32'h80);
        ack(8'hFF);
        chk("R11 all cleared", 32'(comm_dirty), 32'h00);

        // R12 combinational read
        rd_chk("R12 read ctl", 6'h00, 16'h0002);
        rd_chk("R12 read dest", 6'h0E, 16'hBEEF);

        done = 1;
        summary();
        $finish;
    end

endmodule